// File: doc/BRIEF.md
# Mode-Selected Effective Ratio Generator

This block keeps four multiplication ratios, each a 32-bit unsigned fixed-point word, and a two-bit divide code for each one. All four are filled through a plain write port. Two mode pins pick one of the four sets. A global format bit says how the chosen word is read: either 12 integer bits and 20 fraction bits, or 20 integer bits and 12 fraction bits. The block turns the chosen word into one common 20.20 unsigned form, so the digital loop downstream never needs to know which format was used.

A third pin, together with a 3-bit pin-role setting, can switch on the chosen set's divide code. When it is on, the ratio is shifted right by one to four places. The result is held in a register and drives the effective-ratio output. Beside it there is a valid flag, which is low when the chosen word is zero. There is also a one-cycle pulse that marks a new selection or a change in the chosen set's contents.

Top module: `eff_ratio_gen`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_ratio_i` and `wr_div_i` into slot `wr_addr_i` at the clock edge and leaves the other slots unchanged.
- R2: `mode_i` values 0, 1, 2 and 3 select slot 0, 1, 2 and 3.
- R3: With `fmt_hi_res_i` = 1 the word is read as 12.20 and zero-extended into 20.20, so 0x0013A92A gives 0x000013A92A and 0x10000000 gives 0x0010000000.
- R4: With `fmt_hi_res_i` = 0 the word is read as 20.12 and shifted left by 8 into 20.20, so 0x32000000 gives 0x3200000000.
- R5: When `pin_cfg_i` = 3'b011 and `m2_i` = 1, the converted ratio is shifted right by 1, 2, 3 or 4 bits for divide codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R6: For any other `pin_cfg_i`, or with `m2_i` = 0, the converted ratio reaches the output unshifted, whatever the divide code is.
- R7: Outputs are registered. A change on `mode_i`, `m2_i`, `fmt_hi_res_i` or `pin_cfg_i` shows one clock edge later. A write shows two edges later.
- R8: `valid_o` is low, and `ratio_o` is zero, whenever the selected stored word is zero. Otherwise `valid_o` is high.
- R9: `changed_o` is high for exactly one cycle after any of these changes: `mode_i`, `m2_i`, or the selected slot's word or divide code. Writes to other slots, and changes of `fmt_hi_res_i` or `pin_cfg_i` alone, raise no pulse.
- R10: While `rst_ni` is low, all slots are cleared and `ratio_o`, `valid_o` and `changed_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Slot write strobe |
| wr_addr_i | input | 2 | Slot to write |
| wr_ratio_i | input | 32 | Fixed-point ratio word to store |
| wr_div_i | input | 2 | Divide code to store with the word |
| fmt_hi_res_i | input | 1 | 1: 12.20 words, 0: 20.12 words |
| pin_cfg_i | input | 3 | Role of `m2_i`; 3'b011 lets it enable the divider |
| mode_i | input | 2 | Slot select |
| m2_i | input | 1 | Divider enable pin, active when `pin_cfg_i` = 3'b011 |
| ratio_o | output | 40 | Effective ratio, 20.20 unsigned |
| valid_o | output | 1 | Selected word is nonzero |
| changed_o | output | 1 | One-cycle pulse on a new selection |

## Verification
The bench sweeps every combination of format, pin role, divider pin and mode over four slots. The slots hold deliberately different divide codes, so a design that indexes the wrong slot's code, or lets the divider act under a pin role other than 3'b011, shows a wrong value. One stored word has its lowest bit set, which catches a shift that is off by one or that saturates. Pulses are predicted from the mode and pin history alone, so a design that pulses on a format or pin-role change, or never drops the pulse, is caught. A write to a slot that is not selected must leave both the output and the pulse untouched. A zero word must drop the valid flag.

// File: rtl/eff_ratio_pkg.sv
package eff_ratio_pkg;
  localparam int RATIO_W  = 32;
  localparam int INT_HI   = 20;
  localparam int FRAC_HI  = 20;
  localparam int FRAC_LO  = 12;
  localparam int PAD_W    = FRAC_HI - FRAC_LO;
  localparam int OUT_W    = RATIO_W + PAD_W;
  localparam int DIV_W    = 2;
  localparam int CFG_W    = 3;
  localparam logic [CFG_W-1:0] CFG_DIV_PIN = 3'b011;

  typedef struct packed {
    logic [RATIO_W-1:0] word;
    logic [DIV_W-1:0]   div;
  } ratio_set_t;
endpackage

// File: rtl/ratio_bank.sv
module ratio_bank
  import eff_ratio_pkg::*;
#(
  parameter int N_SETS = 4,
  localparam int SEL_W = $clog2(N_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_addr_i,
  input  ratio_set_t       wr_set_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output ratio_set_t       rd_set_o
);
  ratio_set_t slot_q [N_SETS];

  for (genvar g = 0; g < N_SETS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == SEL_W'(g))    slot_q[g] <= wr_set_i;
    end
  end

  assign rd_set_o = slot_q[rd_sel_i];
endmodule

// File: rtl/ratio_scale.sv
module ratio_scale
  import eff_ratio_pkg::*;
(
  input  logic [RATIO_W-1:0] word_i,
  input  logic               fmt_hi_res_i,
  input  logic               div_en_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic [OUT_W-1:0]   ratio_o
);
  logic [OUT_W-1:0] widened;
  logic [DIV_W:0]   shamt;

  always_comb begin
    widened = fmt_hi_res_i ? {{PAD_W{1'b0}}, word_i} : {word_i, {PAD_W{1'b0}}};
    shamt   = {1'b0, div_i} + 1'b1;
    ratio_o = div_en_i ? (widened >> shamt) : widened;
  end
endmodule

// File: rtl/eff_ratio_gen.sv
module eff_ratio_gen
  import eff_ratio_pkg::*;
#(
  parameter int N_SETS = 4,
  localparam int SEL_W = $clog2(N_SETS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_addr_i,
  input  logic [RATIO_W-1:0] wr_ratio_i,
  input  logic [DIV_W-1:0]   wr_div_i,
  input  logic               fmt_hi_res_i,
  input  logic [CFG_W-1:0]   pin_cfg_i,
  input  logic [SEL_W-1:0]   mode_i,
  input  logic               m2_i,
  output logic [OUT_W-1:0]   ratio_o,
  output logic               valid_o,
  output logic               changed_o
);
  localparam int KEY_W = SEL_W + 1 + $bits(ratio_set_t);

  ratio_set_t       sel_set;
  logic [OUT_W-1:0] ratio_d;
  logic             div_en;
  logic [KEY_W-1:0] key_d, key_q;
  logic             primed_q;

  ratio_bank #(.N_SETS(N_SETS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_set_i  ('{word: wr_ratio_i, div: wr_div_i}),
    .rd_sel_i  (mode_i),
    .rd_set_o  (sel_set)
  );

  assign div_en = (pin_cfg_i == CFG_DIV_PIN) && m2_i;

  ratio_scale u_scale (
    .word_i       (sel_set.word),
    .fmt_hi_res_i (fmt_hi_res_i),
    .div_en_i     (div_en),
    .div_i        (sel_set.div),
    .ratio_o      (ratio_d)
  );

  assign key_d = {mode_i, m2_i, sel_set};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_o   <= '0;
      valid_o   <= 1'b0;
      changed_o <= 1'b0;
      key_q     <= '0;
      primed_q  <= 1'b0;
    end else begin
      ratio_o   <= ratio_d;
      valid_o   <= |sel_set.word;
      changed_o <= primed_q && (key_d != key_q);
      key_q     <= key_d;
      primed_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/eff_ratio_gen_chk.sv
module eff_ratio_gen_chk
  import eff_ratio_pkg::*;
#(
  parameter int N_SETS = 4,
  localparam int SEL_W = $clog2(N_SETS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               fmt_hi_res_i,
  input logic [CFG_W-1:0]   pin_cfg_i,
  input logic [SEL_W-1:0]   mode_i,
  input logic               m2_i,
  input logic [OUT_W-1:0]   ratio_o,
  input logic               valid_o,
  input logic               changed_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R9
  mode_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (mode_i != $past(mode_i)) |=> changed_o);

  // R9
  quiet_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($stable(mode_i) && $stable(m2_i) && !$past(wr_en_i)) |=> !changed_o);

  // R8
  zero_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (ratio_o == '0));

  // R4
  lo_fmt_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt_hi_res_i && !(pin_cfg_i == CFG_DIV_PIN && m2_i)) |=> (ratio_o[PAD_W-1:0] == '0));

  // R3
  hi_fmt_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_hi_res_i && !(pin_cfg_i == CFG_DIV_PIN && m2_i)) |=> (ratio_o[OUT_W-1 -: PAD_W] == '0));
endmodule

bind eff_ratio_gen eff_ratio_gen_chk #(.N_SETS(N_SETS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .fmt_hi_res_i (fmt_hi_res_i),
  .pin_cfg_i    (pin_cfg_i),
  .mode_i       (mode_i),
  .m2_i         (m2_i),
  .ratio_o      (ratio_o),
  .valid_o      (valid_o),
  .changed_o    (changed_o)
);

// File: tb/eff_ratio_gen_test.sv
`timescale 1ns/1ps
module eff_ratio_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_ratio_i = '0;
  logic [1:0]  wr_div_i = '0;
  logic        fmt_hi_res_i = 1'b1;
  logic [2:0]  pin_cfg_i = '0;
  logic [1:0]  mode_i = '0;
  logic        m2_i = 1'b0;
  logic [39:0] ratio_o;
  logic        valid_o;
  logic        changed_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] mem_w [4];
  logic [1:0]  mem_d [4];

  always #4 clk_i = ~clk_i;

  eff_ratio_gen uut (.*);

  function automatic logic [39:0] model(input logic [31:0] w, input logic fmt,
                                        input logic [2:0] cfg, input logic m2,
                                        input logic [1:0] d);
    logic [39:0] r;
    r = fmt ? {8'h00, w} : {w, 8'h00};
    if (cfg == 3'b011 && m2) r = r >> (int'(d) + 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_slot(input logic [1:0] a, input logic [31:0] w, input logic [1:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_ratio_i = w; wr_div_i = d;
    mem_w[a] = w; mem_d[a] = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    logic [1:0] pm;
    logic       pm2;
    logic [39:0] hold;
    @(negedge clk_i);
    // R10
    check("R10 ratio", ratio_o, 40'h0);
    check("R10 valid", {39'h0, valid_o}, 40'h0);
    check("R10 changed", {39'h0, changed_o}, 40'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    // R1: load slots, mode 0 selected, slot 0 write shows after two edges with a pulse
    write_slot(2'd0, 32'h0013A92A, 2'd0);
    @(negedge clk_i);
    check("R9 write pulse", {39'h0, changed_o}, 40'h1);
    // R3
    check("R3 12.20 example", ratio_o, 40'h000013A92A);
    check("R8 valid", {39'h0, valid_o}, 40'h1);
    write_slot(2'd1, 32'h10000000, 2'd1);
    write_slot(2'd2, 32'h32000000, 2'd2);
    write_slot(2'd3, 32'h80000001, 2'd3);
    @(negedge clk_i);
    // R1 other-slot writes leave output and pulse alone
    check("R1 slot0 intact", ratio_o, 40'h000013A92A);
    check("R9 no pulse other slot", {39'h0, changed_o}, 40'h0);
    // R2/R3/R4/R5/R6/R7/R9 sweep
    pm = mode_i; pm2 = m2_i;
    for (int f = 1; f >= 0; f--)
      for (int c = 0; c < 8; c++)
        for (int m = 0; m < 2; m++)
          for (int s = 0; s < 4; s++) begin
            fmt_hi_res_i = f[0]; pin_cfg_i = c[2:0]; m2_i = m[0]; mode_i = s[1:0];
            @(negedge clk_i);
            check((c == 3 && m == 1) ? "R5 divided" : "R6 undivided", ratio_o,
                  model(mem_w[s], f[0], c[2:0], m[0], mem_d[s]));
            check("R9 pulse", {39'h0, changed_o},
                  {39'h0, (s[1:0] != pm) || (m[0] != pm2)});
            pm = s[1:0]; pm2 = m[0];
          end
    // R4 example, R2 slot 2
    fmt_hi_res_i = 1'b0; pin_cfg_i = 3'b000; m2_i = 1'b0; mode_i = 2'd2;
    @(negedge clk_i);
    check("R4 20.12 example", ratio_o, 40'h3200000000);
    // R5 divide by 2 of 256
    fmt_hi_res_i = 1'b1; pin_cfg_i = 3'b011; m2_i = 1'b1; mode_i = 2'd0;
    write_slot(2'd0, 32'h10000000, 2'd0);
    @(negedge clk_i);
    check("R5 256/2", ratio_o, 40'h0008000000);
    // R9 format-only change gives no pulse
    @(negedge clk_i);
    hold = ratio_o;
    fmt_hi_res_i = 1'b0;
    @(negedge clk_i);
    check("R9 no pulse on format", {39'h0, changed_o}, 40'h0);
    check("R7 format follows", ratio_o, 40'h0800000000);
    check("R9 format changed value", {39'h0, ratio_o != hold}, 40'h1);
    // R8 zero word
    fmt_hi_res_i = 1'b1; pin_cfg_i = 3'b000; mode_i = 2'd3;
    @(negedge clk_i);
    @(negedge clk_i);
    write_slot(2'd3, 32'h0, 2'd1);
    @(negedge clk_i);
    check("R8 zero valid", {39'h0, valid_o}, 40'h0);
    check("R8 zero ratio", ratio_o, 40'h0);
    check("R9 selected write pulse", {39'h0, changed_o}, 40'h1);
    @(negedge clk_i);
    check("R9 single cycle", {39'h0, changed_o}, 40'h0);
    // R10 reset mid-run
    rst_ni = 1'b0;
    #1;
    check("R10 async clear", ratio_o, 40'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mode_i = 2'd1;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R10 slots cleared", {39'h0, valid_o}, 40'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule